// File: doc/BRIEF.md
# Floating-Point Exception Entry Controller

This block performs the single-step bookkeeping a small processor core does when it takes an exception raised by its floating-point unit. Each cycle it watches two event inputs. One reports a data exception (a bad operand). The other reports an inexact result. From these it decides whether an exception is taken. When one is taken, the block does all of the following in one clock edge: it captures the return address and the prior machine state, writes a cleared copy of the machine state back to the core, rewrites the syndrome register, and raises a fetch redirect to the handler vector.

The two kinds behave differently. A data exception squashes the faulting instruction. It returns to that instruction and records the kind of instruction in the syndrome. An inexact exception lets the instruction complete. It returns to the next instruction and leaves the syndrome alone. The block also issues the reset vector once after reset is released.

The redirect output is a valid/ready stream. `rdr_valid` rises with `rdr_pc`, and both hold steady until the fetch unit asserts `rdr_ready`. `rdr_valid` falls on the edge where `rdr_ready` is sampled high. While a redirect is outstanding, new exception events are ignored rather than queued, so no back-pressure reaches the exception sources.

Top module: `fpx_entry_ctrl`

## Requirements
- R1: While `rst` is high, `rdr_valid`, `state_wr_valid` and `squash` are 0 and `syndrome` is 0. At the first clock edge after `rst` falls, `rdr_valid` rises with `rdr_pc` = {`rst_base`, 2'b00}.
- R2: Once `rdr_valid` is 1, it stays 1 and `rdr_pc` stays unchanged until an edge where `rdr_ready` is 1. At that edge `rdr_valid` goes to 0.
- R3: Exception events arriving while `rdr_valid` is 1, or before the reset redirect has been issued, are ignored. `ret_addr`, `saved_state`, `syndrome` and `rdr_pc` keep their values, and no `state_wr_valid` or `squash` pulse occurs.
- R4: When `hi_pri_pend` is 1, neither exception kind is taken.
- R5: A data exception (`fp_data_exc`=1) sets `ret_addr` to `pc_fault`. It raises a redirect to {`vec_prefix`[31:8], 8'hA0}.
- R6: An inexact exception is taken only when `fp_inexact`=1 and `inexact_en`=1. It sets `ret_addr` to `pc_next` and redirects to {`vec_prefix`[31:8], 8'hB0}.
- R7: If both kinds are raised in the same cycle, the data exception is taken.
- R8: On any taken exception, `saved_state` becomes the `cur_state` value of the taking cycle.
- R9: On any taken exception, `state_wr_valid` pulses for one cycle with `state_wr_data` = `cur_state` with bits [29:16] cleared (the fourteen control/enable fields) and all other bits kept.
- R10: A data exception sets `syndrome` to 0 except bit 7 = `flt_vec_op` and bit 5 = `flt_vle`. An inexact exception leaves `syndrome` unchanged.
- R11: `squash` pulses for one cycle on a taken data exception, and never on an inexact one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_data_exc | input | 1 | Floating-point data exception event |
| fp_inexact | input | 1 | Inexact-result event |
| inexact_en | input | 1 | Inexact exceptions enabled |
| hi_pri_pend | input | 1 | A higher-priority exception is pending |
| flt_vec_op | input | 1 | Faulting instruction was a vector-unit op |
| flt_vle | input | 1 | Faulting instruction used the variable-length encoding |
| pc_fault | input | 32 | Address of the faulting instruction |
| pc_next | input | 32 | Address of the following instruction |
| cur_state | input | 32 | Current machine state |
| vec_prefix | input | 32 | Vector prefix; upper 24 bits used |
| rst_base | input | 30 | Reset base address, word-aligned |
| rdr_ready | input | 1 | Fetch unit accepts redirect |
| rdr_valid | output | 1 | Redirect request valid |
| rdr_pc | output | 32 | Redirect target |
| ret_addr | output | 32 | Saved return address |
| saved_state | output | 32 | Saved prior machine state |
| state_wr_valid | output | 1 | One-cycle machine-state write strobe |
| state_wr_data | output | 32 | Machine state to write |
| syndrome | output | 32 | Exception syndrome register |
| squash | output | 1 | Suppress the faulting instruction |

## Verification
Two functions can land in one cycle: the data exception and the inexact exception, both raised together. The bench provokes this with `inexact_en` high, and again with `hi_pri_pend` high. It judges the first case by the vector offset (0xA0), `ret_addr` equal to `pc_fault`, a rewritten syndrome and a `squash` pulse; in the second case nothing may move. A second collision, an exception arriving while a redirect is still being held, is judged by every saved register keeping its earlier value.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_ROUND = 2'd2
  } fpx_kind_e;

  localparam int SYN_VECOP_BIT = 7;
  localparam int SYN_VLE_BIT   = 5;
  localparam int STATE_CLR_LO  = 16;
  localparam int STATE_CLR_HI  = 29;
endpackage

// File: rtl/fpx_select.sv
module fpx_select
  import fpx_pkg::*;
(
  input  logic      open_win,
  input  logic      data_req,
  input  logic      inexact,
  input  logic      inexact_en,
  input  logic      hi_pri,
  output fpx_kind_e kind
);
  logic round_req;

  always_comb begin
    round_req = inexact && inexact_en;
    kind = KIND_NONE;
    if (open_win && !hi_pri) begin
      if (data_req)       kind = KIND_DATA;
      else if (round_req) kind = KIND_ROUND;
    end
  end
endmodule

// File: rtl/fpx_vector.sv
module fpx_vector
  import fpx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PREFIX_W  = 24,
  parameter logic [ADDR_W-PREFIX_W-1:0] DATA_OFF  = 'hA0,
  parameter logic [ADDR_W-PREFIX_W-1:0] ROUND_OFF = 'hB0
) (
  input  fpx_kind_e          kind,
  input  logic [ADDR_W-1:0]  prefix,
  output logic [ADDR_W-1:0]  vec
);
  localparam int OFF_W = ADDR_W - PREFIX_W;
  logic [OFF_W-1:0] off;

  always_comb begin
    off = (kind == KIND_ROUND) ? ROUND_OFF : DATA_OFF;
    vec = {prefix[ADDR_W-1:OFF_W], off};
  end
endmodule

// File: rtl/fpx_context.sv
module fpx_context
  import fpx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 32,
  parameter int SYN_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  fpx_kind_e          kind,
  input  logic               vec_op,
  input  logic               vle,
  input  logic [ADDR_W-1:0]  pc_fault,
  input  logic [ADDR_W-1:0]  pc_next,
  input  logic [STATE_W-1:0] cur_state,
  output logic [ADDR_W-1:0]  ret_addr,
  output logic [STATE_W-1:0] saved_state,
  output logic               state_wr_valid,
  output logic [STATE_W-1:0] state_wr_data,
  output logic [SYN_W-1:0]   syndrome,
  output logic               squash
);
  localparam logic [STATE_W-1:0] CLR_MASK =
    ((STATE_W'(1) << (STATE_CLR_HI + 1)) - STATE_W'(1)) &
    ~((STATE_W'(1) << STATE_CLR_LO) - STATE_W'(1));
  localparam logic [SYN_W-1:0] SYN_KEEP =
    (SYN_W'(1) << SYN_VECOP_BIT) | (SYN_W'(1) << SYN_VLE_BIT);

  logic take;
  logic [SYN_W-1:0] syn_new;

  always_comb begin
    take = (kind != KIND_NONE);
    syn_new = '0;
    syn_new[SYN_VECOP_BIT] = vec_op;
    syn_new[SYN_VLE_BIT]   = vle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_addr       <= '0;
      saved_state    <= '0;
      state_wr_valid <= 1'b0;
      state_wr_data  <= '0;
      syndrome       <= '0;
      squash         <= 1'b0;
    end else begin
      state_wr_valid <= take;
      squash         <= (kind == KIND_DATA);
      if (take) begin
        saved_state   <= cur_state;
        state_wr_data <= cur_state & ~CLR_MASK;
        ret_addr      <= (kind == KIND_DATA) ? pc_fault : pc_next;
      end
      if (kind == KIND_DATA) syndrome <= syn_new;
    end
  end

  assert_saved_state_R8: assert property (@(posedge clk) disable iff (rst)
    (kind != KIND_NONE) |=> (saved_state == $past(cur_state)));
  assert_state_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    state_wr_valid |-> ((state_wr_data & CLR_MASK) == '0));
  assert_syndrome_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_ROUND) |=> $stable(syndrome));
  assert_syndrome_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (syndrome & ~SYN_KEEP) == '0);
  assert_squash_data_only_R11: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_ROUND) |=> !squash);
endmodule

// File: rtl/fpx_entry_ctrl.sv
module fpx_entry_ctrl
  import fpx_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STATE_W  = 32,
  parameter int SYN_W    = 32,
  parameter int PREFIX_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fp_data_exc,
  input  logic               fp_inexact,
  input  logic               inexact_en,
  input  logic               hi_pri_pend,
  input  logic               flt_vec_op,
  input  logic               flt_vle,
  input  logic [ADDR_W-1:0]  pc_fault,
  input  logic [ADDR_W-1:0]  pc_next,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [ADDR_W-1:0]  vec_prefix,
  input  logic [ADDR_W-3:0]  rst_base,
  input  logic               rdr_ready,
  output logic               rdr_valid,
  output logic [ADDR_W-1:0]  rdr_pc,
  output logic [ADDR_W-1:0]  ret_addr,
  output logic [STATE_W-1:0] saved_state,
  output logic               state_wr_valid,
  output logic [STATE_W-1:0] state_wr_data,
  output logic [SYN_W-1:0]   syndrome,
  output logic               squash
);
  logic              boot_pend;
  logic              open_win;
  fpx_kind_e         kind;
  logic [ADDR_W-1:0] vec;

  assign open_win = !rdr_valid && !boot_pend;

  fpx_select u_sel (
    .open_win   (open_win),
    .data_req   (fp_data_exc),
    .inexact    (fp_inexact),
    .inexact_en (inexact_en),
    .hi_pri     (hi_pri_pend),
    .kind       (kind)
  );

  fpx_vector #(.ADDR_W(ADDR_W), .PREFIX_W(PREFIX_W)) u_vec (
    .kind   (kind),
    .prefix (vec_prefix),
    .vec    (vec)
  );

  fpx_context #(.ADDR_W(ADDR_W), .STATE_W(STATE_W), .SYN_W(SYN_W)) u_ctx (
    .clk            (clk),
    .rst            (rst),
    .kind           (kind),
    .vec_op         (flt_vec_op),
    .vle            (flt_vle),
    .pc_fault       (pc_fault),
    .pc_next        (pc_next),
    .cur_state      (cur_state),
    .ret_addr       (ret_addr),
    .saved_state    (saved_state),
    .state_wr_valid (state_wr_valid),
    .state_wr_data  (state_wr_data),
    .syndrome       (syndrome),
    .squash         (squash)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_pend <= 1'b1;
      rdr_valid <= 1'b0;
      rdr_pc    <= '0;
    end else if (boot_pend) begin
      boot_pend <= 1'b0;
      rdr_valid <= 1'b1;
      rdr_pc    <= {rst_base, 2'b00};
    end else if (rdr_valid) begin
      if (rdr_ready) rdr_valid <= 1'b0;
    end else if (kind != KIND_NONE) begin
      rdr_valid <= 1'b1;
      rdr_pc    <= vec;
    end
  end

  assert_redirect_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rdr_valid && !rdr_ready) |=> (rdr_valid && $stable(rdr_pc)));
  assert_redirect_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (rdr_valid && rdr_ready) |=> !rdr_valid);
  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (rst)
    rdr_valid |=> (!state_wr_valid && !squash));
  assert_hi_pri_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (!rdr_valid && !boot_pend && hi_pri_pend) |=> (!rdr_valid && !state_wr_valid));
  assert_data_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (open_win && !hi_pri_pend && fp_data_exc) |=> (squash && rdr_pc[7:0] == 8'hA0));
endmodule

// File: tb/sim_fpx_entry_ctrl.sv
module sim_fpx_entry_ctrl;
  logic clk = 0, rst = 1;
  logic fp_data_exc = 0, fp_inexact = 0, inexact_en = 0, hi_pri_pend = 0;
  logic flt_vec_op = 0, flt_vle = 0, rdr_ready = 0;
  logic [31:0] pc_fault = 0, pc_next = 0, cur_state = 0, vec_prefix = 0;
  logic [29:0] rst_base = 30'h0123_4567;
  logic rdr_valid, state_wr_valid, squash;
  logic [31:0] rdr_pc, ret_addr, saved_state, state_wr_data, syndrome;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  fpx_entry_ctrl u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic release_rdr();
    rdr_ready = 1; @(negedge clk);
    rdr_ready = 0;
    chk("R2 valid dropped", {31'd0, rdr_valid}, 32'd0);
  endtask

  task automatic fire(logic d, logic r, logic en, logic hi, logic vop, logic vle,
                      logic [31:0] pf, logic [31:0] st, logic [31:0] pre);
    fp_data_exc = d; fp_inexact = r; inexact_en = en; hi_pri_pend = hi;
    flt_vec_op = vop; flt_vle = vle; pc_fault = pf; pc_next = pf + 4;
    cur_state = st; vec_prefix = pre;
    @(negedge clk);
    fp_data_exc = 0; fp_inexact = 0; hi_pri_pend = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", {31'd0, rdr_valid}, 0);
    chk("R1 syndrome in reset", syndrome, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 boot valid", {31'd0, rdr_valid}, 1);
    chk("R1 boot pc", rdr_pc, {rst_base, 2'b00});
    fire(1, 0, 0, 0, 1, 1, 32'h1000, 32'hFFFF_FFFF, 32'hAABB_CC00);
    chk("R3 ignored during boot", {30'd0, state_wr_valid, squash}, 0);
    chk("R3 syndrome kept", syndrome, 0);
    repeat (2) @(negedge clk);
    chk("R2 hold pc", rdr_pc, {rst_base, 2'b00});
    release_rdr();
  endtask

  task automatic t_data(logic vop, logic vle, logic [31:0] pf, logic [31:0] st);
    fire(1, 0, 0, 0, vop, vle, pf, st, 32'h8765_4321);
    chk("R5 valid", {31'd0, rdr_valid}, 1);
    chk("R5 vector", rdr_pc, 32'h8765_43A0);
    chk("R5 ret addr", ret_addr, pf);
    chk("R8 saved state", saved_state, st);
    chk("R9 strobe", {31'd0, state_wr_valid}, 1);
    chk("R9 new state", state_wr_data, st & 32'hC000_FFFF);
    chk("R10 syndrome", syndrome, {24'd0, vop, 1'b0, vle, 5'd0});
    chk("R11 squash", {31'd0, squash}, 1);
    @(negedge clk);
    chk("R11 squash one cycle", {30'd0, squash, state_wr_valid}, 0);
    release_rdr();
  endtask

  task automatic t_round(logic [31:0] pf, logic [31:0] st);
    logic [31:0] syn0 = syndrome;
    fire(0, 1, 1, 0, 0, 0, pf, st, 32'h1122_3344);
    chk("R6 vector", rdr_pc, 32'h1122_33B0);
    chk("R6 ret addr", ret_addr, pf + 4);
    chk("R8 saved state", saved_state, st);
    chk("R9 new state", state_wr_data, st & 32'hC000_FFFF);
    chk("R10 syndrome kept", syndrome, syn0);
    chk("R11 no squash", {31'd0, squash}, 0);
    release_rdr();
  endtask

  task automatic t_round_disabled();
    fire(0, 1, 0, 0, 0, 0, 32'h5000, 32'h1, 32'h1122_3344);
    chk("R6 disabled no redirect", {30'd0, rdr_valid, state_wr_valid}, 0);
  endtask

  task automatic t_hi_pri();
    logic [31:0] ra = ret_addr;
    fire(1, 1, 1, 1, 1, 1, 32'h6000, 32'h2, 32'h3300_0000);
    chk("R4 blocked", {29'd0, rdr_valid, state_wr_valid, squash}, 0);
    chk("R4 ret addr kept", ret_addr, ra);
  endtask

  task automatic t_both();
    fire(1, 1, 1, 0, 0, 1, 32'h7000, 32'h3FFF_0000, 32'h4400_0000);
    chk("R7 data vector", rdr_pc, 32'h4400_00A0);
    chk("R7 ret addr", ret_addr, 32'h7000);
    chk("R7 squash", {31'd0, squash}, 1);
    chk("R9 all cleared", state_wr_data, 0);
    @(negedge clk);
    fire(0, 1, 1, 0, 0, 0, 32'h9000, 32'h5, 32'h5500_0000);
    chk("R3 busy pc kept", rdr_pc, 32'h4400_00A0);
    chk("R3 busy ret kept", ret_addr, 32'h7000);
    chk("R3 busy saved kept", saved_state, 32'h3FFF_0000);
    chk("R3 busy syndrome kept", syndrome, 32'h20);
    release_rdr();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_data(1, 0, 32'h0000_2000, 32'hDEAD_BEEF);
    t_data(0, 1, 32'h0000_2400, 32'h1234_5678);
    t_round(32'h0000_3000, 32'hFFFF_FFFF);
    t_round_disabled();
    t_hi_pri();
    t_both();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule